// File: doc/BRIEF.md
# Indexed Bank Register Address Translator

This block turns processor and video addresses into ROM byte offsets for a cartridge that holds more program and pattern data than the two address spaces can reach at once. Software programs eight 8-bit bank registers, numbered 0 to 7, through a pair of ports. An even-address write in the $8000-$9FFF range picks the register for the next data write and also sets two mode bits. An odd-address write in the same range then loads the chosen register.

The processor side splits $8000-$FFFF into four 8 KB windows. Two of these windows follow bank registers 6 and 7. The other two stay on the last and second-last program banks, and a program-mode bit exchanges the first and third windows. The video side splits $0000-$1FFF into two 2 KB windows, which take their bank numbers from registers 0 and 1, and four 1 KB windows, which take theirs from registers 2 to 5. An inversion bit swaps the lower and upper 4 KB halves of the video space.

A build-time option adds an outer-bank register at $6000-$7FFF. This register confines both ROMs to a sub-region, so that one ROM image can carry several independent games. The translation is purely combinational from the register state. A register write changes the mapping from the clock edge that accepts it. The bank counts are parameters.

Top module: `mapx_bank_xlate`

## Requirements
- R1: A write with `wr_addr[15:13]` = 3'b100 and `wr_addr[0]` = 0 loads the register index from `wr_data[2:0]`, the program mode from `wr_data[6]` and the pattern inversion from `wr_data[7]`.
- R2: A write with `wr_addr[15:13]` = 3'b100 and `wr_addr[0]` = 1 stores `wr_data` into the bank register named by the current index. It leaves the index and both mode bits unchanged.
- R3: Writes with `wr_addr` in $A000-$FFFF, or in $0000-$5FFF, change neither the program mapping nor the pattern mapping.
- R4: With inversion 0, pattern addresses $0000-$07FF use register 0 and $0800-$0FFF use register 1. Each of these registers gives a 2 KB bank: its bit 0 is ignored and replaced by `ppu_addr[10]`. The four 1 KB windows at $1000, $1400, $1800 and $1C00 use registers 2, 3, 4 and 5 in that order.
- R5: With inversion 1, the pattern mapping is the R4 mapping applied to `ppu_addr` with bit 12 inverted. The 1 KB windows then sit at $0000-$0FFF and the 2 KB windows at $1000-$1FFF.
- R6: With program mode 0, the windows selected by `cpu_addr[14:13]` = 0, 1, 2 and 3 map to register 6, register 7, bank PRG_BANKS-2 and bank PRG_BANKS-1. Mode 1 exchanges the banks of windows 0 and 2. Bank numbers are taken modulo the bank count. `prg_offset` is bank × 8192 + `cpu_addr[12:0]`.
- R7: With the outer register present, a write with `wr_addr[15:13]` = 3'b011 stores `wr_data[2:0]` into it. Bit 17 of both the program and the pattern offset then equals outer bit 2. Program offset bit 16 is forced to 1 when outer bits 1:0 are 3; otherwise it is the inner bit 16 ANDed with outer bit 2.
- R8: After reset, all bank registers, the index, both mode bits and the outer register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one per cycle |
| wr_addr | input | 16 | Processor write address |
| wr_data | input | 8 | Processor write data |
| cpu_addr | input | 15 | Processor read address within $8000-$FFFF (bit 15 dropped) |
| prg_offset | output | PRG_AW (18) | Program ROM byte offset |
| ppu_addr | input | 13 | Video pattern address $0000-$1FFF |
| chr_offset | output | CHR_AW (18) | Pattern ROM byte offset |

## Verification
A corrupted index or mode bit does not appear when it is written. It shows one cycle after the next data write, as a register landing in the wrong window, or at once as windows exchanged on both sides. A wrong bank register shows in the very next combinational lookup, but only in the window that the current modes give it. For this reason the bench repeats every window sweep under all four mode combinations and under all eight outer values. Errors in the outer register show only in offset bits 16 and 17, so the sweep covers both low and high inner bank numbers.

// File: rtl/mapx_pkg.sv
// Shared types for the bank translator.
// Assumes eight 8-bit bank registers, packed so they pass through ports.
package mapx_pkg;
    localparam int NUM_BANK_REGS = 8;
    localparam int BANK_W        = 8;
    localparam int IDX_W         = $clog2(NUM_BANK_REGS);

    typedef logic [BANK_W-1:0] bank_t;
    typedef bank_t [NUM_BANK_REGS-1:0] bank_file_t;
endpackage

// File: rtl/mapx_regs.sv
// Register file of the translator: bank registers, index, mode bits and the
// optional outer-bank register. Assumes one write per cycle, with the address
// already qualified by wr_en.
module mapx_regs
    import mapx_pkg::*;
#(
    parameter bit HAS_OUTER = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [15:0]      wr_addr,
    input  logic [7:0]       wr_data,
    output bank_file_t       banks,
    output logic             prg_mode,
    output logic             chr_inv,
    output logic [2:0]       outer
);
    logic [IDX_W-1:0] idx;
    logic             sel_bank;
    logic             sel_outer;

    // Decode the $8000-$9FFF pair and the $6000-$7FFF outer range.
    assign sel_bank  = wr_en && (wr_addr[15:13] == 3'b100);
    assign sel_outer = wr_en && (wr_addr[15:13] == 3'b011);

    // Index/mode capture on even writes, bank load on odd writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            banks    <= '0;
            idx      <= '0;
            prg_mode <= 1'b0;
            chr_inv  <= 1'b0;
        end else if (sel_bank) begin
            if (!wr_addr[0]) begin
                idx      <= wr_data[IDX_W-1:0];
                prg_mode <= wr_data[6];
                chr_inv  <= wr_data[7];
            end else begin
                banks[idx] <= wr_data;
            end
        end
    end

    generate
        if (HAS_OUTER) begin : g_outer
            // Outer-bank register load.
            always_ff @(posedge clk) begin
                if (!rst_n) outer <= '0;
                else if (sel_outer) outer <= wr_data[2:0];
            end

            // R7: the outer register takes the low three data bits.
            a_r7_outer_load: assert property (@(posedge clk) disable iff (!rst_n)
                sel_outer |=> outer == $past(wr_data[2:0]));
        end else begin : g_no_outer
            assign outer = '0;
        end
    endgenerate

    // R1: an even write sets the index and both mode bits.
    a_r1_index_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_bank && !wr_addr[0]) |=>
            (idx == $past(wr_data[IDX_W-1:0]) && prg_mode == $past(wr_data[6])
             && chr_inv == $past(wr_data[7])));

    // R2: an odd write loads the indexed register and keeps the mode bits.
    a_r2_data_load: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_bank && wr_addr[0]) |=>
            (banks[$past(idx)] == $past(wr_data) && $stable(prg_mode) && $stable(chr_inv)));
endmodule

// File: rtl/mapx_prg_xlate.sv
// Program-side translation: picks one of four 8 KB windows from cpu_addr[14:13]
// and applies the outer-bank override to offset bits 16 and 17.
// Assumes a power-of-two PRG_BANKS of at least 32 when the outer register is present.
module mapx_prg_xlate
    import mapx_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    parameter bit HAS_OUTER = 1'b1,
    localparam int PB       = $clog2(PRG_BANKS),
    localparam int PRG_AW   = PB + 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_t             bank6,
    input  bank_t             bank7,
    input  logic              prg_mode,
    input  logic [2:0]        outer,
    input  logic [14:0]       cpu_addr,
    output logic [PRG_AW-1:0] prg_offset
);
    localparam logic [PB-1:0] LAST   = PB'(PRG_BANKS - 1);
    localparam logic [PB-1:0] SECOND = PB'(PRG_BANKS - 2);

    logic [PB-1:0]     bank_sel;
    logic [PRG_AW-1:0] inner;
    logic [BANK_W-1:0] unused_hi;

    assign unused_hi = {bank6[BANK_W-1:PB], bank7[BANK_W-1:PB]} >> 0;

    // Window to bank-number selection under the program mode.
    always_comb begin
        unique case (cpu_addr[14:13])
            2'd0:    bank_sel = prg_mode ? SECOND : bank6[PB-1:0];
            2'd1:    bank_sel = bank7[PB-1:0];
            2'd2:    bank_sel = prg_mode ? bank6[PB-1:0] : SECOND;
            default: bank_sel = LAST;
        endcase
    end

    assign inner = {bank_sel, cpu_addr[12:0]};

    generate
        if (HAS_OUTER) begin : g_outer
            // Outer override of program address bits 16 and 17.
            always_comb begin
                prg_offset     = inner;
                prg_offset[17] = outer[2];
                prg_offset[16] = (&outer[1:0]) | (inner[16] & outer[2]);
            end
        end else begin : g_plain
            logic [2:0] unused_outer;
            assign unused_outer = outer;
            assign prg_offset   = inner;
        end
    endgenerate

    // R6: the top window always reads the last bank.
    a_r6_last_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'b11) |-> bank_sel == LAST);

    // R6: the $A000 window follows register 7 in both modes.
    a_r6_window1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'b01) |-> bank_sel == bank7[PB-1:0]);
endmodule

// File: rtl/mapx_chr_xlate.sv
// Pattern-side translation: two 2 KB windows and four 1 KB windows, with the
// halves swapped by the inversion bit, then the outer override on bit 17.
// Assumes a power-of-two CHR_BANKS of at least 256 when the outer register is present.
module mapx_chr_xlate
    import mapx_pkg::*;
#(
    parameter int CHR_BANKS = 256,
    parameter bit HAS_OUTER = 1'b1,
    localparam int CB       = $clog2(CHR_BANKS),
    localparam int CHR_AW   = CB + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_file_t        banks,
    input  logic              chr_inv,
    input  logic [2:0]        outer,
    input  logic [12:0]       ppu_addr,
    output logic [CHR_AW-1:0] chr_offset
);
    logic              upper;
    bank_t             pair_reg;
    logic [CB-1:0]     bank_sel;
    logic [CHR_AW-1:0] inner;
    bank_t             unused_top;

    assign unused_top = banks[7] ^ banks[6];
    assign upper      = ppu_addr[12] ^ chr_inv;
    assign pair_reg   = ppu_addr[11] ? banks[1] : banks[0];

    // Bank-number selection: 2 KB pairs in the lower half, 1 KB banks in the upper.
    always_comb begin
        if (!upper) bank_sel = {pair_reg[CB-1:1], ppu_addr[10]};
        else        bank_sel = banks[{1'b0, ppu_addr[11:10]} + 3'd2][CB-1:0];
    end

    assign inner = {bank_sel, ppu_addr[9:0]};

    generate
        if (HAS_OUTER) begin : g_outer
            // Outer override of pattern address bit 17.
            always_comb begin
                chr_offset     = inner;
                chr_offset[17] = outer[2];
            end
            logic [1:0] unused_lo;
            assign unused_lo = outer[1:0];
        end else begin : g_plain
            logic [2:0] unused_outer;
            assign unused_outer = outer;
            assign chr_offset   = inner;
        end
    endgenerate

    // R4: inside a 2 KB window, bank bit 0 comes from the address, not the register.
    a_r4_pair_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !upper |-> bank_sel[0] == ppu_addr[10]);

    // R5: in the 1 KB half with inversion set, $0000 reads register 2.
    a_r5_inv_first: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_inv && ppu_addr[12:10] == 3'b000) |-> bank_sel == banks[2][CB-1:0]);
endmodule

// File: rtl/mapx_bank_xlate.sv
// Top of the bank translator: register file plus program and pattern
// translation. Assumes the caller decodes cpu_addr bit 15 and presents only
// $8000-$FFFF reads here.
module mapx_bank_xlate
    import mapx_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    parameter int CHR_BANKS = 256,
    parameter bit HAS_OUTER = 1'b1,
    localparam int PRG_AW   = $clog2(PRG_BANKS) + 13,
    localparam int CHR_AW   = $clog2(CHR_BANKS) + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [14:0]       cpu_addr,
    output logic [PRG_AW-1:0] prg_offset,
    input  logic [12:0]       ppu_addr,
    output logic [CHR_AW-1:0] chr_offset
);
    bank_file_t banks;
    logic       prg_mode;
    logic       chr_inv;
    logic [2:0] outer;

    mapx_regs #(.HAS_OUTER(HAS_OUTER)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .banks(banks), .prg_mode(prg_mode),
        .chr_inv(chr_inv), .outer(outer)
    );

    mapx_prg_xlate #(.PRG_BANKS(PRG_BANKS), .HAS_OUTER(HAS_OUTER)) i_prg (
        .clk(clk), .rst_n(rst_n), .bank6(banks[6]), .bank7(banks[7]),
        .prg_mode(prg_mode), .outer(outer), .cpu_addr(cpu_addr),
        .prg_offset(prg_offset)
    );

    mapx_chr_xlate #(.CHR_BANKS(CHR_BANKS), .HAS_OUTER(HAS_OUTER)) i_chr (
        .clk(clk), .rst_n(rst_n), .banks(banks), .chr_inv(chr_inv),
        .outer(outer), .ppu_addr(ppu_addr), .chr_offset(chr_offset)
    );
endmodule

// File: tb/test_mapx_bank_xlate.sv
// Sweep bench: a bench-side model of the registers, expected offsets computed
// arithmetically, every window checked under each mode and outer value.
module test_mapx_bank_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int PRG_BANKS  = 32;
    localparam int CHR_BANKS  = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [14:0] cpu_addr = '0;
    logic [12:0] ppu_addr = '0;
    logic [17:0] prg_offset;
    logic [17:0] chr_offset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int m_bank [8];
    int m_idx  = 0;
    int m_mode = 0;
    int m_inv  = 0;
    int m_outer = 0;

    mapx_bank_xlate #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS), .HAS_OUTER(1'b1)) i_mapx_bank_xlate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cpu_addr(cpu_addr), .prg_offset(prg_offset),
        .ppu_addr(ppu_addr), .chr_offset(chr_offset)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int outer_prg(input int off);
        int a16, a17;
        a17 = (m_outer >= 4) ? 1 : 0;
        a16 = ((m_outer % 4) == 3) ? 1 : (((off / 65536) % 2) & a17);
        return (off % 65536) + a16 * 65536 + a17 * 131072;
    endfunction

    function automatic int exp_prg(input int a);
        int w, bank;
        w = a / 8192;
        case (w)
            0: bank = (m_mode != 0) ? PRG_BANKS - 2 : m_bank[6];
            1: bank = m_bank[7];
            2: bank = (m_mode != 0) ? m_bank[6] : PRG_BANKS - 2;
            default: bank = PRG_BANKS - 1;
        endcase
        return outer_prg((bank % PRG_BANKS) * 8192 + (a % 8192));
    endfunction

    function automatic int exp_chr(input int a);
        int v, off;
        v = (m_inv != 0) ? (a ^ 4096) : a;
        if (v < 4096) off = ((m_bank[v / 2048] / 2) % (CHR_BANKS / 2)) * 2048 + (v % 2048);
        else          off = (m_bank[2 + (v % 4096) / 1024] % CHR_BANKS) * 1024 + (v % 1024);
        return (off % 131072) + ((m_outer >= 4) ? 131072 : 0);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
        if (addr >= 'h8000 && addr < 'hA000) begin
            if (addr % 2 == 0) begin
                m_idx = data % 8; m_mode = (data / 64) % 2; m_inv = (data / 128) % 2;
            end else m_bank[m_idx] = data;
        end else if (addr >= 'h6000 && addr < 'h8000) m_outer = data % 8;
    endtask

    task automatic set_bank(input int r, input int v);
        wr('h8000 + 2 * r, m_inv * 128 + m_mode * 64 + r);
        wr('h8001, v);
    endtask

    task automatic set_modes(input int mode, input int inv);
        wr('h8000, inv * 128 + mode * 64 + m_idx);
    endtask

    // Sweep program and pattern windows, checking each against the model.
    task automatic sweep(input string ptag, input string ctag);
        for (int a = 0; a < 32768; a += 1024) begin
            cpu_addr = 15'(a + (a / 1024) * 7);
            #1;
            chk(ptag, int'(prg_offset), exp_prg(int'(cpu_addr)));
        end
        for (int a = 0; a < 8192; a += 128) begin
            ppu_addr = 13'(a + (a / 128) % 5);
            #1;
            chk(ctag, int'(chr_offset), exp_chr(int'(ppu_addr)));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_bank[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: all-zero state after reset.
        sweep("R8 reset prg", "R8 reset chr");

        // R4 R5 R6: bank patterns under each of the four mode combinations.
        for (int p = 0; p < 3; p++) begin
            for (int r = 0; r < 8; r++)
                set_bank(r, (p == 2) ? (255 - r * 3) : (r * 37 + p * 11 + 1));
            for (int c = 0; c < 4; c++) begin
                set_modes(c % 2, c / 2);
                sweep("R6 program window", (c / 2 == 0) ? "R4 pattern window" : "R5 inverted window");
            end
        end

        // R1 R2: index set with modes, then data write leaves modes alone.
        wr('h9FFE, 'hC5);            // index 5, mode 1, inversion 1
        wr('h9FFF, 'h9A);            // R5 gets 0x9A
        sweep("R1 mode capture prg", "R2 indexed load chr");
        wr('h8002, 'h02);            // index 2, both modes back to 0
        wr('h8123, 'h41);            // odd data write; bit 6 must not set mode
        sweep("R2 mode kept prg", "R2 mode kept chr");

        // R3: writes outside the two decoded ranges are ignored.
        wr('hA000, 'hFF); wr('hA001, 'hFF); wr('hC000, 'h13); wr('hC001, 'h77);
        wr('hE000, 'hC7); wr('hE001, 'h55); wr('h5FFF, 'h07); wr('h0000, 'hFF);
        sweep("R3 ignored write prg", "R3 ignored write chr");

        // R7: every outer value, with low and high inner bank numbers.
        for (int o = 0; o < 8; o++) begin
            wr('h6000 + o * 'h0101, o + 8 * o);
            for (int h = 0; h < 2; h++) begin
                set_bank(6, h ? 'h1F : 'h05);
                set_bank(7, h ? 'h0B : 'h1A);
                set_bank(0, h ? 'hFE : 'h41);
                set_bank(3, h ? 'h83 : 'h7C);
                sweep("R7 outer prg", "R7 outer chr");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule